// File: doc/BRIEF.md
# Frame-Synced Audio Serial Port (Codec Slave)

This block links processing logic to an audio codec that acts as clock master. The codec drives a bit clock and a frame sync line, runs 64 bit periods per frame at a 44.1 kHz frame rate, and uses separate data lines for the converter input and the converter output. A frame opens with a sync pulse one bit period wide. The left and right 16-bit words then follow back to back, most significant bit first. The port deserialises only the left word from the ADC line and hands it over as a parallel sample with a one-cycle valid strobe. It also serialises a 16-bit parallel sample into the left slot on the DAC line.

Every part of the port runs on the system clock. The bit clock, frame sync and ADC data each pass through a two-flop synchroniser. Edge detection on the synchronised bit clock then paces all activity. The word to transmit is captured when the frame sync is seen, so the processing side may change its input at any time. The port does nothing until the `cfg_done` input reports that the codec has been configured. `cfg_done` is synchronous to `clk`.

Top module: `pcm_frame_port`

## Requirements
- R1: While reset is asserted and just after it, `dac_dat_o` is 0 and `rx_valid_o` is 0.
- R2: While `cfg_done` is 0, sync pulses and data are ignored: `rx_valid_o` stays 0 and `dac_dat_o` stays 0.
- R3: A bit-clock rising edge that finds `fsync_i` high starts a frame. The left-channel MSB is the bit present at the next rising edge.
- R4: The ADC bits sampled at rising edges 1 to 16 after the sync edge form `rx_sample_o`, first bit as bit 15. `rx_sample_o` changes only together with `rx_valid_o`.
- R5: `rx_valid_o` is high for exactly one `clk` cycle per frame, shortly after the rising edge that carries the 16th left bit.
- R6: Right-channel bits (rising edges 17 to 32) and the rest of the frame have no effect on `rx_sample_o`.
- R7: The word on `tx_sample_i` is sent MSB first on `dac_dat_o`. Each bit is changed only after a bit-clock falling edge, so bit k (0 = MSB) is stable at rising edge k+1 after the sync edge.
- R8: `tx_sample_i` is captured at the sync edge. A change during the frame takes effect in the next frame only.
- R9: `dac_dat_o` is 0 at the sync edge and at rising edges 17 to 63 of the frame.
- R10: Bit-clock activity with no sync pulse starts no frame: no `rx_valid_o`, `rx_sample_o` unchanged, and `dac_dat_o` 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_done | input | 1 | Codec configuration finished; port idle while low |
| bclk_i | input | 1 | Codec bit clock (asynchronous) |
| fsync_i | input | 1 | Codec frame sync pulse (asynchronous) |
| adc_dat_i | input | 1 | Serial ADC data from codec |
| dac_dat_o | output | 1 | Serial DAC data to codec |
| rx_sample_o | output | 16 | Last received left-channel sample |
| rx_valid_o | output | 1 | One-cycle strobe: new `rx_sample_o` |
| tx_sample_i | input | 16 | Sample to transmit in the next frame |

## Verification
Full-scale codes (0x8000, 0x7FFF), single-bit words at either end, all-ones and all-zeros, and alternating patterns are sent on the left slot. Each is paired with a different right-channel word. These cases separate bit-order mistakes, off-by-one slot alignment and left/right confusion. The same patterns go out on the DAC line, and every non-left slot is checked to be low. Directed frames cover a transmit word changed mid-frame, a sync pulse while configuration is pending, and a frame of clocks with no sync pulse. These tell a latch-at-sync design apart from one that samples the input live or starts frames without a sync pulse.

// File: rtl/pcm_port_pkg.sv
package pcm_port_pkg;
  // positions of the codec lines inside the synchroniser bundle;
  // the bit clock must sit at index 0 (edge detection is done on it)
  localparam int unsigned SYNC_BCLK  = 0;
  localparam int unsigned SYNC_FSYNC = 1;
  localparam int unsigned SYNC_ADC   = 2;
  localparam int unsigned SYNC_NUM   = 3;

  // slot counter state: 0..W-1 busy, W idle
  function automatic int unsigned slot_cnt_w(input int unsigned w);
    return $clog2(w + 1);
  endfunction
endpackage

// File: rtl/pcm_edge_sync.sv
module pcm_edge_sync #(
  parameter int unsigned N      = 3,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] async_i,
  output logic [N-1:1] level_o,
  output logic         clk_rise_o,
  output logic         clk_fall_o
);
  logic [N-1:0] chain [STAGES];
  logic         clk_prev;

  // first stage samples the asynchronous lines
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain[0] <= '0;
    else        chain[0] <= async_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[s] <= '0;
      else        chain[s] <= chain[s-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) clk_prev <= 1'b0;
    else        clk_prev <= chain[STAGES-1][0];
  end

  assign level_o    = chain[STAGES-1][N-1:1];
  assign clk_rise_o =  chain[STAGES-1][0] & ~clk_prev;
  assign clk_fall_o = ~chain[STAGES-1][0] &  clk_prev;
endmodule

// File: rtl/pcm_slot_ctrl.sv
module pcm_slot_ctrl #(
  parameter int unsigned W     = 16,
  parameter int unsigned CNT_W = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic bclk_rise,
  input  logic bclk_fall,
  input  logic fsync,
  output logic frame_start,
  output logic rx_take,
  output logic rx_last,
  output logic tx_step
);
  localparam logic [CNT_W-1:0] IDLE = CNT_W'(W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(W - 1);

  logic [CNT_W-1:0] rx_slot_q, rx_slot_d;
  logic [CNT_W-1:0] tx_slot_q, tx_slot_d;

  assign frame_start = en & bclk_rise & fsync;
  assign rx_take     = en & bclk_rise & ~fsync & (rx_slot_q != IDLE);
  assign rx_last     = rx_take & (rx_slot_q == LAST);
  assign tx_step     = en & bclk_fall & (tx_slot_q != IDLE);

  always_comb begin
    rx_slot_d = rx_slot_q;
    if (!en)              rx_slot_d = IDLE;
    else if (frame_start) rx_slot_d = '0;
    else if (rx_take)     rx_slot_d = rx_slot_q + 1'b1;
  end

  always_comb begin
    tx_slot_d = tx_slot_q;
    if (!en)              tx_slot_d = IDLE;
    else if (frame_start) tx_slot_d = '0;
    else if (tx_step)     tx_slot_d = tx_slot_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_slot_q <= IDLE;
      tx_slot_q <= IDLE;
    end else begin
      rx_slot_q <= rx_slot_d;
      tx_slot_q <= tx_slot_d;
    end
  end
endmodule

// File: rtl/pcm_rx_deser.sv
module pcm_rx_deser #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         take,
  input  logic         last,
  input  logic         bit_i,
  output logic [W-1:0] sample_o,
  output logic         valid_o
);
  logic [W-1:0] sh_q, sh_d;
  logic [W-1:0] smp_d;

  always_comb begin
    sh_d  = sh_q;
    smp_d = sample_o;
    if (take) sh_d  = {sh_q[W-2:0], bit_i};
    if (last) smp_d = {sh_q[W-2:0], bit_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q     <= '0;
      sample_o <= '0;
      valid_o  <= 1'b0;
    end else begin
      sh_q     <= sh_d;
      sample_o <= smp_d;
      valid_o  <= last;
    end
  end
endmodule

// File: rtl/pcm_tx_ser.sv
module pcm_tx_ser #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         load,
  input  logic         step,
  input  logic         bclk_fall,
  input  logic [W-1:0] word_i,
  output logic         dat_o
);
  logic [W-1:0] sh_q, sh_d;
  logic         dat_d;

  always_comb begin
    sh_d  = sh_q;
    dat_d = dat_o;
    if (load)      sh_d = word_i;
    else if (step) sh_d = {sh_q[W-2:0], 1'b0};
    if (!en)            dat_d = 1'b0;
    else if (bclk_fall) dat_d = step ? sh_q[W-1] : 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      dat_o <= 1'b0;
    end else begin
      sh_q  <= sh_d;
      dat_o <= dat_d;
    end
  end
endmodule

// File: rtl/pcm_frame_port.sv
module pcm_frame_port #(
  parameter int unsigned SAMPLE_W    = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_done,
  input  logic                bclk_i,
  input  logic                fsync_i,
  input  logic                adc_dat_i,
  output logic                dac_dat_o,
  output logic [SAMPLE_W-1:0] rx_sample_o,
  output logic                rx_valid_o,
  input  logic [SAMPLE_W-1:0] tx_sample_i
);
  import pcm_port_pkg::*;

  localparam int unsigned CNT_W = slot_cnt_w(SAMPLE_W);

  // reset: asserted asynchronously, released on clk
  logic [1:0] rst_pipe;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_int_n = rst_pipe[1];

  logic [SYNC_NUM-1:0] codec_raw;
  logic [SYNC_NUM-1:1] codec_lvl;
  logic                bclk_rise, bclk_fall;
  logic                frame_start, rx_take, rx_last, tx_step;

  always_comb begin
    codec_raw             = '0;
    codec_raw[SYNC_BCLK]  = bclk_i;
    codec_raw[SYNC_FSYNC] = fsync_i;
    codec_raw[SYNC_ADC]   = adc_dat_i;
  end

  pcm_edge_sync #(.N(SYNC_NUM), .STAGES(SYNC_STAGES)) sync_i (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .async_i    (codec_raw),
    .level_o    (codec_lvl),
    .clk_rise_o (bclk_rise),
    .clk_fall_o (bclk_fall)
  );

  pcm_slot_ctrl #(.W(SAMPLE_W), .CNT_W(CNT_W)) ctrl_i (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .en          (cfg_done),
    .bclk_rise   (bclk_rise),
    .bclk_fall   (bclk_fall),
    .fsync       (codec_lvl[SYNC_FSYNC]),
    .frame_start (frame_start),
    .rx_take     (rx_take),
    .rx_last     (rx_last),
    .tx_step     (tx_step)
  );

  pcm_rx_deser #(.W(SAMPLE_W)) rx_i (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .take     (rx_take),
    .last     (rx_last),
    .bit_i    (codec_lvl[SYNC_ADC]),
    .sample_o (rx_sample_o),
    .valid_o  (rx_valid_o)
  );

  pcm_tx_ser #(.W(SAMPLE_W)) tx_i (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .en        (cfg_done),
    .load      (frame_start),
    .step      (tx_step),
    .bclk_fall (bclk_fall),
    .word_i    (tx_sample_i),
    .dat_o     (dac_dat_o)
  );
endmodule

// File: rtl/pcm_frame_port_chk.sv
module pcm_frame_port_chk #(
  parameter int unsigned W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         cfg_done,
  input logic         bclk_rise,
  input logic         bclk_fall,
  input logic         dac_dat,
  input logic         rx_valid,
  input logic [W-1:0] rx_sample
);
  // R2
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_done |=> (!rx_valid && !dac_dat));

  // R5
  valid_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);

  // R5
  valid_after_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> $past(bclk_rise));

  // R4
  sample_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_valid |-> $stable(rx_sample));

  // R7
  dac_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dac_dat != $past(dac_dat)) |-> ($past(bclk_fall) || $past(!cfg_done)));
endmodule

bind pcm_frame_port pcm_frame_port_chk #(.W(SAMPLE_W)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .cfg_done  (cfg_done),
  .bclk_rise (bclk_rise),
  .bclk_fall (bclk_fall),
  .dac_dat   (dac_dat_o),
  .rx_valid  (rx_valid_o),
  .rx_sample (rx_sample_o)
);

// File: tb/pcm_frame_port_tb.sv
`timescale 1ns/1ps
module pcm_frame_port_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_done;
  logic        bclk_i;
  logic        fsync_i;
  logic        adc_dat_i;
  logic        dac_dat_o;
  logic [15:0] rx_sample_o;
  logic        rx_valid_o;
  logic [15:0] tx_sample_i;

  int n_chk  = 0;
  int n_fail = 0;
  int vcnt   = 0;
  logic [15:0] vlast;
  logic [63:0] dac_cap;
  logic        mid_en  = 1'b0;
  logic [15:0] mid_val = '0;

  // left, right, tx
  localparam logic [47:0] VEC [8] = '{
    {16'h8000, 16'h7FFF, 16'h8000},
    {16'h7FFF, 16'h8000, 16'h7FFF},
    {16'h0001, 16'hFFFF, 16'h0001},
    {16'hFFFF, 16'h0000, 16'hFFFF},
    {16'h0000, 16'hFFFF, 16'h0000},
    {16'hA5A5, 16'h5A5A, 16'h5A5A},
    {16'h5A5A, 16'hA5A5, 16'hA5A5},
    {16'h1234, 16'hFEDC, 16'hC001}
  };

  always #2.5 clk = ~clk;

  pcm_frame_port dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_done    (cfg_done),
    .bclk_i      (bclk_i),
    .fsync_i     (fsync_i),
    .adc_dat_i   (adc_dat_i),
    .dac_dat_o   (dac_dat_o),
    .rx_sample_o (rx_sample_o),
    .rx_valid_o  (rx_valid_o),
    .tx_sample_i (tx_sample_i)
  );

  always @(negedge clk) begin
    if (rx_valid_o) begin
      vcnt  = vcnt + 1;
      vlast = rx_sample_o;
    end
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] left_word(input logic [63:0] cap);
    logic [15:0] w;
    for (int k = 0; k < 16; k++) w[15-k] = cap[k+1];
    return w;
  endfunction

  function automatic logic [63:0] other_bits(input logic [63:0] cap);
    logic [63:0] m;
    m = cap;
    for (int k = 1; k <= 16; k++) m[k] = 1'b0;
    return m;
  endfunction

  // one 64-slot frame; 80 ns bit period, codec drives on falls
  task automatic run_frame(input logic [15:0] l, input logic [15:0] r, input logic sync);
    for (int s = 0; s < 64; s++) begin
      bclk_i  = 1'b0;
      fsync_i = sync && (s == 0);
      if (s >= 1 && s <= 16)       adc_dat_i = l[16-s];
      else if (s >= 17 && s <= 32) adc_dat_i = r[32-s];
      else                         adc_dat_i = 1'b0;
      if (mid_en && s == 5) tx_sample_i = mid_val;
      #40;
      bclk_i     = 1'b1;
      dac_cap[s] = dac_dat_o;
      #40;
    end
    bclk_i  = 1'b0;
    fsync_i = 1'b0;
    #40;
  endtask

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [15:0] l, r, t;
    rst_n = 1'b0; cfg_done = 1'b0; bclk_i = 1'b0; fsync_i = 1'b0;
    adc_dat_i = 1'b0; tx_sample_i = 16'h0000;
    #1;
    #50;
    chk("R1 dac in reset", 64'(dac_dat_o), 64'd0);
    chk("R1 valid in reset", 64'(rx_valid_o), 64'd0);
    rst_n = 1'b1;
    #50;
    chk("R1 dac after reset", 64'(dac_dat_o), 64'd0);
    chk("R1 valid after reset", 64'(rx_valid_o), 64'd0);

    // R2: configuration pending, sync pulse must be ignored
    tx_sample_i = 16'hFFFF;
    vcnt = 0;
    run_frame(16'hBEEF, 16'h1111, 1'b1);
    chk("R2 no valid while unconfigured", 64'(vcnt), 64'd0);
    chk("R2 dac low while unconfigured", dac_cap, 64'd0);

    cfg_done = 1'b1;
    #100;
    // R3 R4 R5 R6 R7 R9: table walk
    for (int v = 0; v < 8; v++) begin
      {l, r, t} = VEC[v];
      tx_sample_i = t;
      vcnt = 0;
      run_frame(l, r, 1'b1);
      chk("R5 one valid per frame", 64'(vcnt), 64'd1);
      chk("R4 R6 left sample", 64'(vlast), 64'(l));
      chk("R7 R3 dac left word", 64'(left_word(dac_cap)), 64'(t));
      chk("R9 dac low outside left slot", other_bits(dac_cap), 64'd0);
    end

    // R8: mid-frame change of tx word
    tx_sample_i = 16'hC3A1;
    mid_en = 1'b1; mid_val = 16'h0F0F;
    run_frame(16'h0000, 16'h0000, 1'b1);
    chk("R8 word latched at sync", 64'(left_word(dac_cap)), 64'h0000_0000_0000_C3A1);
    mid_en = 1'b0;
    run_frame(16'h0000, 16'h0000, 1'b1);
    chk("R8 new word next frame", 64'(left_word(dac_cap)), 64'h0000_0000_0000_0F0F);

    // R10: clocks without sync
    vcnt = 0;
    run_frame(16'h6C6C, 16'h9393, 1'b1);
    chk("R10 reference frame", 64'(vlast), 64'h6C6C);
    vcnt = 0;
    run_frame(16'h3333, 16'hCCCC, 1'b0);
    chk("R10 no valid without sync", 64'(vcnt), 64'd0);
    chk("R10 sample unchanged", 64'(rx_sample_o), 64'h6C6C);
    chk("R10 dac low without sync", dac_cap, 64'd0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule